// File: doc/BRIEF.md
# Sensor Control Register with Timed Non-Volatile Commit

This block holds the 16-bit control word of a temperature-sensor controller and presents it on a simple register bus. The bus has an address, a write enable with write data, and a read strobe with registered read data. The word selects the conversion rate, the shutdown state, two comparator channels (each with a mode bit and an output polarity bit), and two command bits. The command bits start a one-shot conversion or request a soft reset. Four limit flags are produced by comparator logic elsewhere. They appear in the readback image but cannot be written.

A host write has side effects beyond storage. Every accepted write emits a pulse that aborts the conversion in progress. The command bits turn into one-cycle request pulses and never read back as one. Every read emits a read-event pulse, which the comparator logic uses to clear latched window-mode flags.

When the non-volatile update input is high, a write does not touch the live register. It is captured into a shadow store that stands in for non-volatile memory, and a busy flag rises. The busy flag stays up for a programming window counted on a 1 ms tick input. When the window ends, the live register is reloaded from the shadow store. While busy, writes are dropped and a sticky error bit is set.

Top module: `sensor_cfg_reg`

## Requirements
- R1: After reset the readback image is 16'hA000 with all flag inputs low. `rate_sel` is 3'b101. `shutdown`, `mode1`, `pol1`, `mode2`, `pol2`, `nv_busy`, `nv_err` and all pulse outputs are 0.
- R2: A write with `nv_update` low, when not busy, stores these writable fields, visible on the outputs the cycle after the write:
  - bits 15:13 rate
  - bit 11 shutdown
  - bit 8 channel-1 mode
  - bit 7 channel-1 polarity
  - bit 4 channel-2 mode
  - bit 3 channel-2 polarity
- R3: Bits 12, 2, 1 and 0 always read as 0. Values written to the flag bits 10, 9, 6 and 5 are ignored: those bits read back only from the flag inputs.
- R4: Readback bit 10 follows `flag_hi1` and bit 6 follows `flag_hi2`. Bit 9 follows `flag_lo1` only while the channel-1 mode bit is 0 and reads 0 when it is 1. Bit 5 does the same with `flag_lo2` and the channel-2 mode bit.
- R5: An accepted write with bit 12 = 1 and bit 11 = 1 raises `oneshot_pulse` for one cycle, the cycle after the write. If bit 11 = 0, bit 12 produces no pulse.
- R6: An accepted write with bit 1 = 1 raises `soft_rst_req` for one cycle, the cycle after the write. The other written fields are stored as normal.
- R7: Every accepted write to the register address, on either path, raises `conv_abort` for exactly one cycle, the cycle after the write.
- R8: A read strobe at the register address places the readback image on `bus_rd_data` and raises `rd_event` in the following cycle. Otherwise `bus_rd_data` is 0 and `rd_event` is 0.
- R9: Reads and writes at any other address leave the fields unchanged and produce no pulse.
- R10: A write with `nv_update` high, when not busy, leaves the fields unchanged and raises `nv_busy` the next cycle. `nv_busy` holds through 15 ticks of `tick_1ms`. On the edge that samples the 16th tick, `nv_busy` falls and the fields take the written value.
- R11: A write while `nv_busy` is high is dropped: no pulse, no field or shadow change. It sets `nv_err`, which stays high until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 16 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 16 | Registered read data |
| nv_update | input | 1 | Route writes to the timed non-volatile commit |
| tick_1ms | input | 1 | One-cycle millisecond tick |
| flag_hi1 | input | 1 | Channel-1 high flag from comparator logic |
| flag_lo1 | input | 1 | Channel-1 low flag from comparator logic |
| flag_hi2 | input | 1 | Channel-2 high flag from comparator logic |
| flag_lo2 | input | 1 | Channel-2 low flag from comparator logic |
| rate_sel | output | 3 | Conversion rate select |
| shutdown | output | 1 | Shutdown mode |
| mode1 | output | 1 | Channel-1 mode (1 = threshold with hysteresis) |
| pol1 | output | 1 | Channel-1 output polarity |
| mode2 | output | 1 | Channel-2 mode |
| pol2 | output | 1 | Channel-2 output polarity |
| oneshot_pulse | output | 1 | Single-conversion request pulse |
| conv_abort | output | 1 | Abort-conversion pulse on each accepted write |
| soft_rst_req | output | 1 | Soft-reset request pulse |
| rd_event | output | 1 | Pulse after each read of the register |
| nv_busy | output | 1 | Non-volatile commit in progress |
| nv_err | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
The bench runs the commit window to its edge. It checks the fields after the 15th tick and again after the 16th. A counter that is off by one would commit early, or leave busy up one tick too long.

It writes during the busy window and expects no abort pulse, a raised error bit, and a final value equal to the first committed write. A design that queued or overwrote the shadow would show the later data instead.

It writes ones into the flag, command and reserved bit positions, and toggles the channel modes while the low flags are high. A design that stored those bits, or masked the wrong low flag, would show up in the readback image. One-shot writes with shutdown clear, and accesses to a foreign address, must produce no pulse at all.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int REG_W = 16;
  localparam logic [REG_W-1:0] CFG_RESET = 16'hA000;
  localparam logic [REG_W-1:0] CFG_WMASK = 16'hE998;

  localparam int RATE_LSB  = 13;
  localparam int RATE_W    = 3;
  localparam int ONESHOT_B = 12;
  localparam int SHDN_B    = 11;
  localparam int HI1_B     = 10;
  localparam int LO1_B     = 9;
  localparam int MODE1_B   = 8;
  localparam int POL1_B    = 7;
  localparam int HI2_B     = 6;
  localparam int LO2_B     = 5;
  localparam int MODE2_B   = 4;
  localparam int POL2_B    = 3;
  localparam int SRST_B    = 1;

  function automatic logic [REG_W-1:0] keep_writable(input logic [REG_W-1:0] d);
    return d & CFG_WMASK;
  endfunction

  function automatic logic [REG_W-1:0] read_image(
    input logic [REG_W-1:0] live,
    input logic hi1, input logic lo1,
    input logic hi2, input logic lo2);
    logic [REG_W-1:0] img;
    img          = live & CFG_WMASK;
    img[HI1_B]   = hi1;
    img[LO1_B]   = lo1 & ~live[MODE1_B];
    img[HI2_B]   = hi2;
    img[LO2_B]   = lo2 & ~live[MODE2_B];
    return img;
  endfunction
endpackage

// File: rtl/scfg_write_decode.sv
module scfg_write_decode
  import scfg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              nv_update,
  input  logic              busy,
  output logic              wr_hit,
  output logic              wr_accept,
  output logic              wr_drop,
  output logic              direct_wr,
  output logic              nv_start,
  output logic              req_oneshot,
  output logic              req_srst
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_ADDR);

  always_comb begin
    wr_hit      = wr_en && (addr == MY_ADDR);
    wr_accept   = wr_hit && !busy;
    wr_drop     = wr_hit && busy;
    direct_wr   = wr_accept && !nv_update;
    nv_start    = wr_accept && nv_update;
    req_oneshot = wr_accept && wdata[ONESHOT_B] && wdata[SHDN_B];
    req_srst    = wr_accept && wdata[SRST_B];
  end
endmodule

// File: rtl/scfg_nv_commit.sv
module scfg_nv_commit
  import scfg_pkg::*;
#(
  parameter int NV_MS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REG_W-1:0] wdata,
  input  logic             tick,
  output logic             busy,
  output logic             commit,
  output logic [REG_W-1:0] shadow
);
  localparam int CNT_W = (NV_MS > 1) ? $clog2(NV_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NV_MS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign commit = busy && tick && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      shadow <= CFG_RESET;
    end else if (start) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      shadow <= keep_writable(wdata);
    end else if (commit) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
    end else if (busy && tick) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scfg_readback.sv
module scfg_readback
  import scfg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  live,
  input  logic              hi1,
  input  logic              lo1,
  input  logic              hi2,
  input  logic              lo2,
  output logic [REG_W-1:0]  rd_data,
  output logic              rd_evt
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CFG_ADDR);
  logic rd_hit;
  assign rd_hit = rd_en && (addr == MY_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_evt  <= 1'b0;
    end else begin
      rd_evt  <= rd_hit;
      rd_data <= rd_hit ? read_image(live, hi1, lo1, hi2, lo2) : '0;
    end
  end
endmodule

// File: rtl/sensor_cfg_reg.sv
module sensor_cfg_reg
  import scfg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1,
  parameter int NV_MS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [15:0]       bus_wr_data,
  input  logic              bus_rd_en,
  output logic [15:0]       bus_rd_data,
  input  logic              nv_update,
  input  logic              tick_1ms,
  input  logic              flag_hi1,
  input  logic              flag_lo1,
  input  logic              flag_hi2,
  input  logic              flag_lo2,
  output logic [2:0]        rate_sel,
  output logic              shutdown,
  output logic              mode1,
  output logic              pol1,
  output logic              mode2,
  output logic              pol2,
  output logic              oneshot_pulse,
  output logic              conv_abort,
  output logic              soft_rst_req,
  output logic              rd_event,
  output logic              nv_busy,
  output logic              nv_err
);
  logic             wr_hit, wr_accept, wr_drop, direct_wr, nv_start;
  logic             req_oneshot, req_srst, nv_commit;
  logic [REG_W-1:0] shadow_q;
  logic [REG_W-1:0] live_q;

  scfg_write_decode #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_dec (
    .addr(bus_addr), .wr_en(bus_wr_en), .wdata(bus_wr_data),
    .nv_update(nv_update), .busy(nv_busy),
    .wr_hit(wr_hit), .wr_accept(wr_accept), .wr_drop(wr_drop),
    .direct_wr(direct_wr), .nv_start(nv_start),
    .req_oneshot(req_oneshot), .req_srst(req_srst)
  );

  scfg_nv_commit #(.NV_MS(NV_MS)) u_nv (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .wdata(bus_wr_data),
    .tick(tick_1ms), .busy(nv_busy), .commit(nv_commit), .shadow(shadow_q)
  );

  scfg_readback #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_rb (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd_en(bus_rd_en),
    .live(live_q), .hi1(flag_hi1), .lo1(flag_lo1), .hi2(flag_hi2),
    .lo2(flag_lo2), .rd_data(bus_rd_data), .rd_evt(rd_event)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= CFG_RESET;
    end else if (direct_wr) begin
      live_q <= keep_writable(bus_wr_data);
    end else if (nv_commit) begin
      live_q <= shadow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_abort    <= 1'b0;
      oneshot_pulse <= 1'b0;
      soft_rst_req  <= 1'b0;
      nv_err        <= 1'b0;
    end else begin
      conv_abort    <= wr_accept;
      oneshot_pulse <= req_oneshot;
      soft_rst_req  <= req_srst;
      if (wr_drop) nv_err <= 1'b1;
    end
  end

  assign rate_sel = live_q[RATE_LSB +: RATE_W];
  assign shutdown = live_q[SHDN_B];
  assign mode1    = live_q[MODE1_B];
  assign pol1     = live_q[POL1_B];
  assign mode2    = live_q[MODE2_B];
  assign pol2     = live_q[POL2_B];
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_hit,
  input logic        wr_accept,
  input logic        nv_start,
  input logic        nv_commit,
  input logic        bus_rd_en,
  input logic        rd_hit_in,
  input logic [15:0] bus_wr_data,
  input logic [15:0] bus_rd_data,
  input logic [2:0]  rate_sel,
  input logic        shutdown,
  input logic        mode1,
  input logic        pol1,
  input logic        mode2,
  input logic        pol2,
  input logic        oneshot_pulse,
  input logic        conv_abort,
  input logic        soft_rst_req,
  input logic        rd_event,
  input logic        nv_busy,
  input logic        nv_err
);
  AST_ABORT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> conv_abort); // R7
  AST_ABORT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> $past(wr_accept)); // R7
  AST_ONESHOT_NEEDS_SD: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_pulse |-> ($past(bus_wr_data[11]) && $past(wr_accept))); // R5
  AST_SRST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && bus_wr_data[1]) |=> soft_rst_req); // R6
  AST_RD_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_in |=> rd_event); // R8
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_event |-> (bus_rd_data == 16'h0000)); // R8
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> $past(nv_start)); // R10
  AST_FIELDS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && !nv_commit) |=> $stable({rate_sel, shutdown, mode1, pol1, mode2, pol2})); // R10
  AST_DROP_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && nv_busy) |=> (nv_err && !conv_abort)); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    nv_err |=> nv_err); // R11
endmodule

bind sensor_cfg_reg scfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_accept(wr_accept),
  .nv_start(nv_start), .nv_commit(nv_commit), .bus_rd_en(bus_rd_en),
  .rd_hit_in(bus_rd_en && (bus_addr == 4'(CFG_ADDR))),
  .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
  .rate_sel(rate_sel), .shutdown(shutdown), .mode1(mode1), .pol1(pol1),
  .mode2(mode2), .pol2(pol2), .oneshot_pulse(oneshot_pulse),
  .conv_abort(conv_abort), .soft_rst_req(soft_rst_req), .rd_event(rd_event),
  .nv_busy(nv_busy), .nv_err(nv_err)
);

// File: tb/sensor_cfg_reg_test.sv
module sensor_cfg_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] CFG = 4'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [15:0] bus_wr_data = '0;
  logic        bus_rd_en = 1'b0;
  logic [15:0] bus_rd_data;
  logic        nv_update = 1'b0;
  logic        tick_1ms = 1'b0;
  logic        flag_hi1 = 1'b0, flag_lo1 = 1'b0, flag_hi2 = 1'b0, flag_lo2 = 1'b0;
  logic [2:0]  rate_sel;
  logic        shutdown, mode1, pol1, mode2, pol2;
  logic        oneshot_pulse, conv_abort, soft_rst_req, rd_event, nv_busy, nv_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic s_abort, s_oneshot, s_srst;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_cfg_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .nv_update(nv_update), .tick_1ms(tick_1ms),
    .flag_hi1(flag_hi1), .flag_lo1(flag_lo1), .flag_hi2(flag_hi2), .flag_lo2(flag_lo2),
    .rate_sel(rate_sel), .shutdown(shutdown), .mode1(mode1), .pol1(pol1),
    .mode2(mode2), .pol2(pol2), .oneshot_pulse(oneshot_pulse),
    .conv_abort(conv_abort), .soft_rst_req(soft_rst_req), .rd_event(rd_event),
    .nv_busy(nv_busy), .nv_err(nv_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected image, built field by field
  function automatic logic [15:0] img(input logic [2:0] r, input logic sd,
      input logic m1, input logic p1, input logic m2, input logic p2,
      input logic h1, input logic l1, input logic h2, input logic l2);
    return {r, 1'b0, sd, h1, (m1 ? 1'b0 : l1), m1, p1,
            h2, (m2 ? 1'b0 : l2), m2, p2, 3'b000};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic nv);
    @(negedge clk);
    bus_addr = a; bus_wr_data = d; nv_update = nv; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; nv_update = 1'b0;
    s_abort = conv_abort; s_oneshot = oneshot_pulse; s_srst = soft_rst_req;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d, output logic ev);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rd_data; ev = rd_event;
  endtask

  task automatic tick();
    @(negedge clk); tick_1ms = 1'b1;
    @(negedge clk); tick_1ms = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic ev;
    chk("R1 rate", 32'(rate_sel), 32'd5);
    chk("R1 bits", 32'({shutdown, mode1, pol1, mode2, pol2}), 32'd0);
    chk("R1 pulses/busy", 32'({oneshot_pulse, conv_abort, soft_rst_req, rd_event, nv_busy, nv_err}), 32'd0);
    rd(CFG, d, ev);
    chk("R1 image", 32'(d), 32'hA000);
  endtask

  task automatic t_direct();
    logic [15:0] d; logic ev;
    wr(CFG, {3'b011, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 3'b000}, 1'b0);
    chk("R7 abort on direct write", 32'(s_abort), 32'd1);
    chk("R2 fields", 32'({rate_sel, shutdown, mode1, pol1, mode2, pol2}), {26'd0, 3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
    @(negedge clk);
    chk("R7 abort one cycle", 32'(conv_abort), 32'd0);
    rd(CFG, d, ev);
    chk("R2 readback", 32'(d), 32'(img(3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 0, 0, 0)));
  endtask

  task automatic t_ro_bits();
    logic [15:0] d; logic ev;
    wr(CFG, 16'h0666, 1'b0); // only flag/command/reserved bits and bit 11 clear
    chk("R3 fields cleared", 32'({rate_sel, shutdown, mode1, pol1, mode2, pol2}), 32'd0);
    rd(CFG, d, ev);
    chk("R3 ro/zero bits", 32'(d), 32'h0000);
    wr(CFG, 16'hFFFF, 1'b0);
    rd(CFG, d, ev);
    chk("R3 all ones image", 32'(d), 32'(img(3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 0, 0, 0)));
  endtask

  task automatic t_flags();
    logic [15:0] d; logic ev;
    wr(CFG, 16'h0000, 1'b0);
    flag_hi1 = 1'b1; flag_lo1 = 1'b1; flag_hi2 = 1'b1; flag_lo2 = 1'b1;
    rd(CFG, d, ev);
    chk("R4 flags window mode", 32'(d), 32'(img(0, 0, 0, 0, 0, 0, 1, 1, 1, 1)));
    wr(CFG, 16'h0100, 1'b0); // channel-1 mode set
    rd(CFG, d, ev);
    chk("R4 lo1 masked by mode1", 32'(d), 32'(img(0, 0, 1, 0, 0, 0, 1, 1, 1, 1)));
    wr(CFG, 16'h0010, 1'b0); // channel-2 mode set
    rd(CFG, d, ev);
    chk("R4 lo2 masked by mode2", 32'(d), 32'(img(0, 0, 0, 0, 1, 0, 1, 1, 1, 1)));
    flag_hi1 = 1'b0; flag_lo1 = 1'b0; flag_hi2 = 1'b0; flag_lo2 = 1'b0;
  endtask

  task automatic t_oneshot();
    wr(CFG, 16'h1800, 1'b0);
    chk("R5 oneshot with shutdown", 32'(s_oneshot), 32'd1);
    @(negedge clk);
    chk("R5 oneshot one cycle", 32'(oneshot_pulse), 32'd0);
    wr(CFG, 16'h1000, 1'b0);
    chk("R5 no oneshot without shutdown", 32'(s_oneshot), 32'd0);
  endtask

  task automatic t_softrst();
    wr(CFG, 16'h4002, 1'b0);
    chk("R6 soft reset pulse", 32'(s_srst), 32'd1);
    chk("R6 other fields stored", 32'(rate_sel), 32'd2);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(soft_rst_req), 32'd0);
  endtask

  task automatic t_other_addr();
    logic [15:0] d; logic ev;
    wr(4'd2, 16'hFFFF, 1'b0);
    chk("R9 no abort other addr", 32'({s_abort, s_oneshot, s_srst}), 32'd0);
    chk("R9 fields unchanged", 32'(rate_sel), 32'd2);
    rd(4'd3, d, ev);
    chk("R9 no read event other addr", 32'({d, ev}), 32'd0);
    rd(CFG, d, ev);
    chk("R8 read event", 32'(ev), 32'd1);
    @(negedge clk);
    chk("R8 event one cycle, data cleared", 32'({bus_rd_data, rd_event}), 32'd0);
  endtask

  task automatic t_nv_commit();
    logic [15:0] d; logic ev;
    wr(CFG, 16'hA000, 1'b0);
    wr(CFG, 16'h4100, 1'b1);
    chk("R7 abort on nv write", 32'(s_abort), 32'd1);
    chk("R10 busy raised", 32'(nv_busy), 32'd1);
    chk("R10 live held", 32'({rate_sel, mode1}), {28'd0, 3'd5, 1'b0});
    for (int i = 0; i < 15; i++) tick();
    chk("R10 busy after 15 ticks", 32'(nv_busy), 32'd1);
    chk("R10 live held after 15 ticks", 32'(rate_sel), 32'd5);
    tick();
    chk("R10 busy drops on 16th tick", 32'(nv_busy), 32'd0);
    chk("R10 committed fields", 32'({rate_sel, mode1}), {28'd0, 3'd2, 1'b1});
    rd(CFG, d, ev);
    chk("R10 committed image", 32'(d), 32'h4100);
    chk("R11 no error yet", 32'(nv_err), 32'd0);
  endtask

  task automatic t_busy_drop();
    wr(CFG, 16'h2008, 1'b1);
    wr(CFG, 16'hE000, 1'b0);
    chk("R11 dropped write no abort", 32'({s_abort, s_oneshot, s_srst}), 32'd0);
    chk("R11 error set", 32'(nv_err), 32'd1);
    chk("R11 live unchanged", 32'(rate_sel), 32'd2);
    wr(CFG, 16'hC000, 1'b1);
    for (int i = 0; i < 16; i++) tick();
    chk("R11 shadow kept first value", 32'({rate_sel, pol2, nv_busy}), {27'd0, 3'd1, 1'b1, 1'b0});
    chk("R11 error sticky", 32'(nv_err), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_ro_bits();
    t_flags();
    t_oneshot();
    t_softrst();
    t_other_addr();
    t_nv_commit();
    t_busy_drop();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule